// File: doc/BRIEF.md
# Stack Pull Sequencer

The block moves a run of consecutive words from a push-down stack into a block of general registers. A one-cycle start supplies a base register number, a word count and the 64-bit stack pointer doubleword. The doubleword holds a top-of-stack address, a space count, a word count and two trap-inhibit bits. In the cycle after start, the sequencer evaluates the stack limits. It then either finishes at once with a limit trap or an abort, or begins the transfer.

In the transfer, the word at the top of the stack goes to the highest-numbered destination register, and each later word, one address lower, goes to the next register down. A stack address below the register count is served from the register file read port. Any other address is served by one memory read, and the sequencer waits for that read's response before it issues the next one. A successful run ends with an updated pointer doubleword and a new condition code. A memory fault ends the run with a fault trap. Registers already written keep their values, and neither the pointer nor the condition code is written.

The controller has seven states. IDLE goes to CHECK on start. CHECK goes to DONE_LIMIT if a limit condition holds, and to ISSUE otherwise. In ISSUE, a local word is written at once: the state stays in ISSUE, or goes to DONE_OK after the last word. A memory word sends ISSUE to WAIT. WAIT goes to DONE_FAULT on a fault. On a response it goes to ISSUE, or to DONE_OK after the last word. Each DONE state returns to IDLE after one cycle.

Top module: `stack_pull_seq`

## Requirements
- R1: After reset, busy_o, done_o, rf_we_o, mem_rd_o, sp_we_o and cc_we_o are all 0.
- R2: busy_o is 1 from the cycle after an accepted start until the cycle after done_o. A start_i pulse while busy_o is 1 has no effect on the writes or the outcome of the run in progress.
- R3: The word count n is count_i, where a value of 0 means 16. The k-th register write (k = 0 .. n-1) goes to register (reg_base_i + n - 1 - k) mod 16 and carries the word at stack address (top - k) mod 2^17.
- R4: The doubleword fields are: top-of-stack in sp_dw_i[48:32], space-count inhibit in [31], space count in [30:16], word-count inhibit in [15], word count in [14:0]. On success, sp_we_o pulses with done_o. In sp_new_o, top becomes top - n (mod 2^17), the space count becomes space + n, and the word count becomes words - n. Bits [63:49] and both inhibit bits are unchanged.
- R5: On success, cc_we_o pulses with cc_o = 4'b0001 if the new word count is 0, and 4'b0000 otherwise.
- R6: "Short" means word count < n. "Over" means space count + n > 32767. A limit trap (limit_trap_o) occurs if short holds with its inhibit clear, or if over holds with its inhibit clear. Otherwise, if short or over holds, the run aborts (abort_o). Either outcome gives done_o in the second cycle after start, with no register write, no memory read and no pointer write.
- R7: On abort, cc_we_o pulses with cc_o = {space count == 0, over, short, word count == 0} (bit 3 down to bit 0). On a limit trap, cc_we_o stays 0.
- R8: A mem_fault_i during WAIT ends the run with fault_trap_o and done_o. Earlier register writes stand. No further writes occur, and sp_we_o and cc_we_o stay 0.
- R9: A stack address below 16 is read through rf_rd_idx_o / rf_rd_data_i in a single cycle, and mem_rd_o stays 0 for that word.
- R10: Each memory word causes exactly one mem_rd_o pulse at its address. No new read is issued before mem_rvalid_i or mem_fault_i answers the previous one.
- R11: done_o lasts one cycle. With it, exactly one of sp_we_o, limit_trap_o, abort_o and fault_trap_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| reg_base_i | input | 4 | Lowest destination register |
| count_i | input | 4 | Word count, 0 means 16 |
| sp_dw_i | input | 64 | Stack pointer doubleword |
| rf_rd_idx_o | output | 4 | Register file read index for local stack words |
| rf_rd_data_i | input | 32 | Register file read data, combinational |
| rf_we_o | output | 1 | Register write strobe |
| rf_widx_o | output | 4 | Register write index |
| rf_wdata_o | output | 32 | Register write data |
| mem_rd_o | output | 1 | Memory read request, one cycle |
| mem_addr_o | output | 17 | Memory word address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_fault_i | input | 1 | Protection or nonexistent-address fault for the pending read |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Run finished, one cycle |
| sp_we_o | output | 1 | Write strobe for the updated doubleword |
| sp_new_o | output | 64 | Updated doubleword |
| cc_we_o | output | 1 | Condition code write strobe |
| cc_o | output | 4 | Condition code value |
| limit_trap_o | output | 1 | Stack limit trap, with done |
| abort_o | output | 1 | Run aborted by an inhibited limit, with done |
| fault_trap_o | output | 1 | Memory fault trap, with done |

## Verification
The bound checker checks the cycle-level rules on every cycle. done_o lasts one cycle and carries a single outcome. A started run raises busy, and no strobe appears while idle. Traps never write the condition code, local addresses never reach memory, and reads do not overlap. The bench scenarios alone can show the values. These are the descending register order, the wrap of register numbers and addresses, the pointer arithmetic, the condition code encodings for each limit combination, the split between register-file and memory sources, the partial writes before a fault, and the fact that a start while busy is ignored.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;

    localparam int DW_W     = 64;
    localparam int ADDR_W   = 17;
    localparam int CNT_W    = 15;
    localparam int CC_W     = 4;
    localparam int KEEP_W   = DW_W - (ADDR_W + 1 + CNT_W + 1 + CNT_W);

    localparam int WORDS_LSB = 0;
    localparam int TW_BIT    = WORDS_LSB + CNT_W;
    localparam int SPACE_LSB = TW_BIT + 1;
    localparam int TS_BIT    = SPACE_LSB + CNT_W;
    localparam int TOS_LSB   = TS_BIT + 1;
    localparam int KEEP_LSB  = TOS_LSB + ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] tos;
        logic              ts;
        logic [CNT_W-1:0]  space;
        logic              tw;
        logic [CNT_W-1:0]  words;
    } sp_fields_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE_OK,
        ST_DONE_LIMIT,
        ST_DONE_FAULT
    } pull_state_e;

endpackage

// File: rtl/pull_limit_eval.sv
module pull_limit_eval
    import pull_seq_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  sp_fields_t       fld_i,
    input  logic [REG_W:0]   n_i,
    output logic             trap_o,
    output logic             abort_o,
    output logic [CC_W-1:0]  cc_abort_o,
    output logic [CC_W-1:0]  cc_ok_o,
    output sp_fields_t       fld_new_o
);
    localparam int PAD_C = CNT_W - (REG_W + 1);
    localparam int PAD_A = ADDR_W - (REG_W + 1);
    localparam logic [CNT_W:0] SPACE_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] n_c;
    logic [CNT_W:0]   space_sum;
    logic             short_w;
    logic             over_w;

    always_comb begin
        n_c       = {{PAD_C{1'b0}}, n_i};
        space_sum = {1'b0, fld_i.space} + {1'b0, n_c};
        short_w   = fld_i.words < n_c;
        over_w    = space_sum > SPACE_MAX;
        trap_o    = (short_w && !fld_i.tw) || (over_w && !fld_i.ts);
        abort_o   = !trap_o && (short_w || over_w);
        cc_abort_o = {fld_i.space == '0, over_w, short_w, fld_i.words == '0};
    end

    always_comb begin
        fld_new_o       = fld_i;
        fld_new_o.tos   = fld_i.tos - {{PAD_A{1'b0}}, n_i};
        fld_new_o.space = space_sum[CNT_W-1:0];
        fld_new_o.words = fld_i.words - n_c;
        cc_ok_o         = {{(CC_W-1){1'b0}}, fld_new_o.words == '0};
    end

endmodule

// File: rtl/pull_addr_gen.sv
module pull_addr_gen
    import pull_seq_pkg::*;
#(
    parameter int REG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] tos_i,
    input  logic [REG_W-1:0]  base_i,
    input  logic [REG_W:0]    n_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [REG_W-1:0]  widx_o,
    output logic              last_o,
    output logic              local_o
);
    localparam logic [ADDR_W-1:0] LOCAL_TOP = ADDR_W'(2 ** REG_W);

    logic [REG_W-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (clear_i) begin
            step_q <= '0;
        end else if (step_i) begin
            step_q <= step_q + REG_W'(1);
        end
    end

    always_comb begin
        addr_o  = tos_i - {{(ADDR_W-REG_W){1'b0}}, step_q};
        widx_o  = base_i + n_i[REG_W-1:0] - REG_W'(1) - step_q;
        last_o  = ({1'b0, step_q} == (n_i - (REG_W+1)'(1)));
        local_o = addr_o < LOCAL_TOP;
    end

endmodule

// File: rtl/stack_pull_seq.sv
module stack_pull_seq
    import pull_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_W-1:0]  reg_base_i,
    input  logic [REG_W-1:0]  count_i,
    input  logic [DW_W-1:0]   sp_dw_i,
    output logic [REG_W-1:0]  rf_rd_idx_o,
    input  logic [DATA_W-1:0] rf_rd_data_i,
    output logic              rf_we_o,
    output logic [REG_W-1:0]  rf_widx_o,
    output logic [DATA_W-1:0] rf_wdata_o,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_fault_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              sp_we_o,
    output logic [DW_W-1:0]   sp_new_o,
    output logic              cc_we_o,
    output logic [CC_W-1:0]   cc_o,
    output logic              limit_trap_o,
    output logic              abort_o,
    output logic              fault_trap_o
);
    localparam logic [REG_W:0] FULL_N = (REG_W+1)'(2 ** REG_W);

    pull_state_e       state_q, state_d;
    sp_fields_t        fld_q, fld_new;
    logic [KEEP_W-1:0] keep_q;
    logic [REG_W-1:0]  base_q;
    logic [REG_W:0]    n_q;
    logic              accept;
    logic              step;
    logic              lim_trap, lim_abort;
    logic [CC_W-1:0]   cc_abort, cc_ok;
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  widx;
    logic              last_w, local_w;

    assign accept = (state_q == ST_IDLE) && start_i;

    // request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q  <= '0;
            keep_q <= '0;
            base_q <= '0;
            n_q    <= '0;
        end else if (accept) begin
            fld_q  <= sp_dw_i[KEEP_LSB-1:0];
            keep_q <= sp_dw_i[DW_W-1:KEEP_LSB];
            base_q <= reg_base_i;
            n_q    <= (count_i == '0) ? FULL_N : {1'b0, count_i};
        end
    end

    pull_limit_eval #(.REG_W(REG_W)) u_limit (
        .fld_i      (fld_q),
        .n_i        (n_q),
        .trap_o     (lim_trap),
        .abort_o    (lim_abort),
        .cc_abort_o (cc_abort),
        .cc_ok_o    (cc_ok),
        .fld_new_o  (fld_new)
    );

    pull_addr_gen #(.REG_W(REG_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .step_i  (step),
        .tos_i   (fld_q.tos),
        .base_i  (base_q),
        .n_i     (n_q),
        .addr_o  (addr),
        .widx_o  (widx),
        .last_o  (last_w),
        .local_o (local_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                state_d = (lim_trap || lim_abort) ? ST_DONE_LIMIT : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (!local_w)    state_d = ST_WAIT;
                else if (last_w) state_d = ST_DONE_OK;
            end
            ST_WAIT: begin
                if (mem_fault_i)       state_d = ST_DONE_FAULT;
                else if (mem_rvalid_i) state_d = last_w ? ST_DONE_OK : ST_ISSUE;
            end
            ST_DONE_OK,
            ST_DONE_LIMIT,
            ST_DONE_FAULT: state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        done_o       = 1'b0;
        rf_we_o      = 1'b0;
        rf_wdata_o   = '0;
        mem_rd_o     = 1'b0;
        sp_we_o      = 1'b0;
        cc_we_o      = 1'b0;
        cc_o         = '0;
        limit_trap_o = 1'b0;
        abort_o      = 1'b0;
        fault_trap_o = 1'b0;
        step         = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CHECK: ;
            ST_ISSUE: begin
                if (local_w) begin
                    rf_we_o    = 1'b1;
                    rf_wdata_o = rf_rd_data_i;
                    step       = 1'b1;
                end else begin
                    mem_rd_o   = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!mem_fault_i && mem_rvalid_i) begin
                    rf_we_o    = 1'b1;
                    rf_wdata_o = mem_rdata_i;
                    step       = 1'b1;
                end
            end
            ST_DONE_OK: begin
                done_o  = 1'b1;
                sp_we_o = 1'b1;
                cc_we_o = 1'b1;
                cc_o    = cc_ok;
            end
            ST_DONE_LIMIT: begin
                done_o       = 1'b1;
                limit_trap_o = lim_trap;
                abort_o      = lim_abort;
                cc_we_o      = lim_abort;
                cc_o         = lim_abort ? cc_abort : '0;
            end
            ST_DONE_FAULT: begin
                done_o       = 1'b1;
                fault_trap_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign rf_rd_idx_o = addr[REG_W-1:0];
    assign rf_widx_o   = widx;
    assign mem_addr_o  = addr;
    assign sp_new_o    = {keep_q, fld_new};

endmodule

// File: rtl/stack_pull_seq_chk.sv
module stack_pull_seq_chk
    import pull_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              rf_we_o,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rvalid_i,
    input logic              mem_fault_i,
    input logic              sp_we_o,
    input logic              cc_we_o,
    input logic              limit_trap_o,
    input logic              abort_o,
    input logic              fault_trap_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(rf_we_o || mem_rd_o || done_o || sp_we_o || cc_we_o)) else $error("idle strobe"); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o) else $error("start did not raise busy"); // R2
    AST_SP_WITH_CC: assert property (@(posedge clk) disable iff (!rst_n)
        sp_we_o |-> (done_o && cc_we_o)) else $error("pointer write outside done"); // R4
    AST_TRAP_NO_CC: assert property (@(posedge clk) disable iff (!rst_n)
        limit_trap_o |-> !cc_we_o) else $error("trap wrote cc"); // R7
    AST_FAULT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_trap_o |-> !(cc_we_o || sp_we_o || rf_we_o)) else $error("fault updated state"); // R8
    AST_LOCAL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> (mem_addr_o >= ADDR_W'(16))) else $error("local address sent to memory"); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |=> !mem_rd_o) else $error("back-to-back reads"); // R10
    AST_READ_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_rvalid_i && !mem_fault_i) |=> !done_o || fault_trap_o || !sp_we_o) else $error("read skipped"); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R11
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($countones({sp_we_o, limit_trap_o, abort_o, fault_trap_o}) == 1)) else $error("outcome not unique"); // R11
endmodule

bind stack_pull_seq stack_pull_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rf_we_o      (rf_we_o),
    .mem_rd_o     (mem_rd_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_fault_i  (mem_fault_i),
    .sp_we_o      (sp_we_o),
    .cc_we_o      (cc_we_o),
    .limit_trap_o (limit_trap_o),
    .abort_o      (abort_o),
    .fault_trap_o (fault_trap_o)
);

// File: tb/stack_pull_seq_tb_top.sv
`timescale 1ns/1ps
module stack_pull_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  reg_base_i = '0;
    logic [3:0]  count_i = '0;
    logic [63:0] sp_dw_i = '0;
    logic [3:0]  rf_rd_idx_o;
    logic [31:0] rf_rd_data_i;
    logic        rf_we_o;
    logic [3:0]  rf_widx_o;
    logic [31:0] rf_wdata_o;
    logic        mem_rd_o;
    logic [16:0] mem_addr_o;
    logic        mem_rvalid_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_fault_i = 1'b0;
    logic        busy_o, done_o, sp_we_o, cc_we_o;
    logic [63:0] sp_new_o;
    logic [3:0]  cc_o;
    logic        limit_trap_o, abort_o, fault_trap_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    stack_pull_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_base_i(reg_base_i),
        .count_i(count_i), .sp_dw_i(sp_dw_i), .rf_rd_idx_o(rf_rd_idx_o),
        .rf_rd_data_i(rf_rd_data_i), .rf_we_o(rf_we_o), .rf_widx_o(rf_widx_o),
        .rf_wdata_o(rf_wdata_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .mem_fault_i(mem_fault_i),
        .busy_o(busy_o), .done_o(done_o), .sp_we_o(sp_we_o), .sp_new_o(sp_new_o),
        .cc_we_o(cc_we_o), .cc_o(cc_o), .limit_trap_o(limit_trap_o), .abort_o(abort_o),
        .fault_trap_o(fault_trap_o)
    );

    // register file model
    logic [31:0] rf_mem [16];
    initial for (int i = 0; i < 16; i++) rf_mem[i] = 32'hA000_0000 + 32'(i) * 32'h111;
    assign rf_rd_data_i = rf_mem[rf_rd_idx_o];
    always @(posedge clk) if (rf_we_o) rf_mem[rf_widx_o] <= rf_wdata_o;

    // expectations
    int          exp_idx[$];
    logic [31:0] exp_data[$];
    logic [16:0] exp_maddr[$];
    int          cur_lat = 1;
    int          cur_fault = -1;
    int          rd_num = 0;
    int          resp_cnt = 0;
    int          resp_num = 0;
    logic [16:0] resp_addr = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [16:0] a);
        return {15'h2B4D, a};
    endfunction

    function automatic logic [63:0] mk_sp(input logic [14:0] keep, input logic [16:0] tos,
                                          input logic ts, input logic [14:0] space,
                                          input logic tw, input logic [14:0] words);
        return {keep, tos, ts, space, tw, words};
    endfunction

    // memory responder, driven one time unit after the rising edge
    always @(posedge clk) begin
        #1;
        mem_rvalid_i = 1'b0;
        mem_fault_i  = 1'b0;
        if (resp_cnt > 0) begin
            resp_cnt--;
            if (resp_cnt == 0) begin
                if (resp_num == cur_fault) mem_fault_i = 1'b1;
                else begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = mem_word(resp_addr);
                end
            end
        end
        if (mem_rd_o && rst_n) begin
            chk(resp_cnt == 0, "R10", "read issued while one is pending", 64'(resp_cnt), 64'd0);
            resp_cnt  = cur_lat;
            resp_addr = mem_addr_o;
            resp_num  = rd_num;
            rd_num++;
        end
    end

    // per-cycle monitor against the expectation queues
    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy_o)
                chk(!rf_we_o && !mem_rd_o, "R2", "strobe while idle", {62'd0, rf_we_o, mem_rd_o}, 64'd0);
            if (mem_rd_o) begin
                if (exp_maddr.size() == 0)
                    chk(1'b0, "R9", "unexpected memory read", 64'(mem_addr_o), 64'd0);
                else begin
                    logic [16:0] ea;
                    ea = exp_maddr.pop_front();
                    chk(mem_addr_o == ea, "R10", "read address", 64'(mem_addr_o), 64'(ea));
                end
            end
            if (rf_we_o) begin
                if (exp_idx.size() == 0)
                    chk(1'b0, "R3", "unexpected register write", 64'(rf_widx_o), 64'd0);
                else begin
                    int          ei;
                    logic [31:0] ed;
                    ei = exp_idx.pop_front();
                    ed = exp_data.pop_front();
                    chk(rf_widx_o == 4'(ei), "R3", "write index", 64'(rf_widx_o), 64'(ei));
                    chk(rf_wdata_o == ed, "R3", "write data", 64'(rf_wdata_o), 64'(ed));
                end
            end
        end
    end

    // kind: 0 success, 1 limit trap, 2 abort, 3 fault
    task automatic run_case(input logic [3:0] base, input logic [3:0] cnt, input logic [63:0] sp,
                            input int lat, input int fault_at, input bit poke);
        int          n, kind, cyc, nwr;
        logic [16:0] tos, a;
        logic [14:0] space, words;
        logic        ts, tw, shrt, over, trap;
        logic [63:0] esp;
        logic [3:0]  ecc;
        n     = (cnt == 0) ? 16 : int'(cnt);
        tos   = sp[48:32]; ts = sp[31]; space = sp[30:16]; tw = sp[15]; words = sp[14:0];
        shrt  = int'(words) < n;
        over  = int'(space) + n > 32767;
        trap  = (shrt && !tw) || (over && !ts);
        kind  = trap ? 1 : ((shrt || over) ? 2 : ((fault_at >= 0) ? 3 : 0));
        esp   = sp;
        esp[48:32] = tos - 17'(n);
        esp[30:16] = space + 15'(n);
        esp[14:0]  = words - 15'(n);
        ecc   = (kind == 2) ? {space == 0, over, shrt, words == 0}
                            : {3'b000, esp[14:0] == 0};
        nwr   = (kind == 0) ? n : ((kind == 3) ? fault_at : 0);
        for (int k = 0; k < n; k++) begin
            a = tos - 17'(k);
            if (kind == 0 || kind == 3) begin
                if (a >= 16 && (kind == 0 || k <= fault_at)) exp_maddr.push_back(a);
                if (k < nwr) begin
                    exp_idx.push_back((int'(base) + n - 1 - k) % 16);
                    exp_data.push_back((a < 16) ? rf_mem[a[3:0]] : mem_word(a));
                end
            end
        end
        cur_lat = lat; cur_fault = fault_at; rd_num = 0;
        @(negedge clk);
        start_i = 1'b1; reg_base_i = base; count_i = cnt; sp_dw_i = sp;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o, "R2", "busy after start", 64'(busy_o), 64'd1);
        cyc = 1;
        if (poke) begin
            start_i = 1'b1; reg_base_i = 4'hF; count_i = 4'h1; sp_dw_i = '1;
        end
        while (!done_o && cyc < 400) begin
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        chk(done_o, "R11", "done seen", 64'(done_o), 64'd1);
        if (kind == 1 || kind == 2)
            chk(cyc == 2, "R6", "limit decision cycle", 64'(cyc), 64'd2);
        chk(limit_trap_o == (kind == 1), "R6", "limit trap", 64'(limit_trap_o), 64'(kind == 1));
        chk(abort_o == (kind == 2), "R6", "abort", 64'(abort_o), 64'(kind == 2));
        chk(fault_trap_o == (kind == 3), "R8", "fault trap", 64'(fault_trap_o), 64'(kind == 3));
        chk(sp_we_o == (kind == 0), "R4", "pointer write", 64'(sp_we_o), 64'(kind == 0));
        chk(cc_we_o == (kind == 0 || kind == 2), "R7", "cc write", 64'(cc_we_o), 64'(kind == 0 || kind == 2));
        if (kind == 0) begin
            chk(sp_new_o == esp, "R4", "new pointer", sp_new_o, esp);
            chk(cc_o == ecc, "R5", "success cc", 64'(cc_o), 64'(ecc));
        end
        if (kind == 2) chk(cc_o == ecc, "R7", "abort cc", 64'(cc_o), 64'(ecc));
        @(negedge clk);
        chk(!done_o && !busy_o, "R11", "single-cycle done", {62'd0, done_o, busy_o}, 64'd0);
        chk(exp_idx.size() == 0, "R3", "writes missing", 64'(exp_idx.size()), 64'd0);
        chk(exp_maddr.size() == 0, "R10", "reads missing", 64'(exp_maddr.size()), 64'd0);
        exp_idx.delete(); exp_data.delete(); exp_maddr.delete();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !rf_we_o && !mem_rd_o && !sp_we_o && !cc_we_o, "R1", "reset outputs",
            {58'd0, busy_o, done_o, rf_we_o, mem_rd_o, sp_we_o, cc_we_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_case(4'd2, 4'd4, mk_sp(15'h1234, 17'h01000, 0, 15'd100, 0, 15'd10), 1, -1, 0);   // R3 R4 R5
        run_case(4'd5, 4'd0, mk_sp(15'h7ABC, 17'h00400, 0, 15'd7, 0, 15'd16), 3, -1, 0);     // R3 wrap, R5 zero
        run_case(4'd1, 4'd3, mk_sp(15'h0, 17'h00300, 0, 15'd50, 0, 15'd2), 1, -1, 0);        // R6 short trap
        run_case(4'd1, 4'd2, mk_sp(15'h0, 17'h00300, 0, 15'd0, 1, 15'd0), 1, -1, 0);         // R7 abort 1011
        run_case(4'd1, 4'd2, mk_sp(15'h0, 17'h00300, 0, 15'd32766, 1, 15'd40), 1, -1, 0);    // R6 over trap
        run_case(4'd1, 4'd1, mk_sp(15'h0, 17'h00300, 1, 15'd32767, 1, 15'd0), 1, -1, 0);     // R7 abort 0111
        run_case(4'd1, 4'd1, mk_sp(15'h0, 17'h00300, 0, 15'd32767, 1, 15'd0), 1, -1, 0);     // R6 mixed trap
        run_case(4'd8, 4'd3, mk_sp(15'h0, 17'h00005, 0, 15'd10, 0, 15'd20), 1, -1, 0);       // R9 all local
        run_case(4'd0, 4'd4, mk_sp(15'h0, 17'h00011, 0, 15'd10, 0, 15'd20), 2, -1, 0);       // R9 R10 crossing
        run_case(4'd4, 4'd5, mk_sp(15'h0, 17'h00200, 0, 15'd10, 0, 15'd20), 2, 2, 0);        // R8 fault
        run_case(4'd12, 4'd6, mk_sp(15'h0F0F, 17'h1FFFF, 1, 15'd300, 1, 15'd300), 3, -1, 1); // R2 start ignored
        run_case(4'd9, 4'd3, mk_sp(15'h0, 17'h00001, 0, 15'd4, 0, 15'd3), 1, -1, 0);         // R3 address wrap
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule